// File: doc/BRIEF.md
# Descriptor Command Sequencer

This block walks a chain of 16-byte command descriptors held in memory and carries each one out in turn. For every descriptor it reads the header words, hands transfer commands to an external data mover, and then writes the descriptor's last word back with the residual count and a completion status. Moving the bytes themselves is the data mover's job, not this block's.

Each descriptor carries three 2-bit policies. They decide whether the sequencer raises an interrupt, branches to another descriptor, or stalls before completing. Each policy tests one of three condition inputs from the device. This lets a chain signal, loop or hold, depending on device state, without software stepping in. A register block drives the run, pause and wake controls.

Top module: `dma_cmd_seq`

## Requirements
- R1: After reset, `active`, `stopped`, `dead`, `irq`, `mem_req` and `xfer_req` are all 0.
- R2: A descriptor at address A is read as 32-bit words. Word A holds the requested count in bits 15:0 and the command word in bits 31:16. Word A+4 holds the data address. Word A+8 holds the command-dependent field. For opcodes 0 to 5 (command bits 15:12), one transfer request is issued that carries the opcode, the key (command bits 10:8), the data address, the requested count and the command-dependent field.
- R3: Each completed descriptor writes word A+12. Bits 15:0 hold the residual count. Bits 31:16 hold the status 0x8000 | int_cond<<2 | br_cond<<1 | wait_cond. The residual count is the data mover's value for a transfer, and the requested count for opcode 6 (no-op).
- R4: Opcode 7 halts the chain. It leaves `cmd_ptr` on that descriptor, does no write-back and no transfer, and sets `stopped`.
- R5: Command bits 5:4 set the interrupt policy: 0 never, 1 if `int_cond`=1, 2 if `int_cond`=0, 3 always. When the policy holds, `irq` pulses for exactly one cycle, right after the write-back is accepted.
- R6: Command bits 3:2 set the branch policy, tested against `br_cond` with the same encoding. When the branch is taken, the next descriptor address is the command-dependent field. Otherwise the next address is the current address plus 16.
- R7: Command bits 1:0 set the wait policy, tested against `wait_cond` with the same encoding. While the policy holds, the sequencer holds off the write-back, and it re-tests the policy every cycle.
- R8: Descriptor addresses have their low 4 bits cleared. This applies both to the start pointer and to branch targets.
- R9: A `wake` pulse while stopped fetches the descriptor at `cmd_ptr` again.
- R10: While `pause` is 1, no new descriptor is fetched after the current one finishes. When `run` is 0 between descriptors or while stopped, the sequencer returns to idle.
- R11: An error response on any memory access sets `dead`. After that, no further memory or transfer requests are made until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables the sequencer; idle loads the start pointer when this is 1 |
| pause | input | 1 | Holds between descriptors |
| wake | input | 1 | Restarts from a stop |
| start_ptr | input | 32 | First descriptor address |
| int_cond | input | 1 | Condition tested by the interrupt policy |
| br_cond | input | 1 | Condition tested by the branch policy |
| wait_cond | input | 1 | Condition tested by the wait policy |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write-back, 0 for a fetch |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_op | output | 4 | Opcode |
| xfer_key | output | 3 | Key |
| xfer_addr | output | 32 | Data address |
| xfer_count | output | 16 | Requested count |
| xfer_dep | output | 32 | Command-dependent field |
| xfer_done | input | 1 | One-cycle completion from the data mover |
| xfer_resid | input | 16 | Residual count, valid with `xfer_done` |
| irq | output | 1 | One-cycle interrupt pulse |
| active | output | 1 | Processing a descriptor chain |
| stopped | output | 1 | Halted on a stop descriptor |
| dead | output | 1 | Halted by a memory error |
| cmd_ptr | output | 32 | Current descriptor address |

## Verification
Once `run` rises, the first fetch request appears one cycle later. Each word fetch completes in the cycle its acknowledge arrives. A decode cycle follows. The transfer request is then held until `xfer_done`. The wait stage lasts at least one cycle. The write-back is accepted in the cycle its acknowledge arrives, and `irq` and the pointer update fall in the cycle after that. Because of this, the bench never samples mid-chain. It waits for `stopped` or `dead` on falling edges and then compares memory contents, the recorded transfer fields, the interrupt count and `cmd_ptr` with values it computes from the policy encodings. The exact one-cycle placement of `irq` after the write-back is left to the bound properties. The stall tests check the write-back word 30 cycles into a hold, well past any path through the pipeline.

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        pause,
  input  logic        wake,
  input  logic [31:0] start_ptr,
  input  logic        int_cond,
  input  logic        br_cond,
  input  logic        wait_cond,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  output logic        xfer_req,
  output logic [3:0]  xfer_op,
  output logic [2:0]  xfer_key,
  output logic [31:0] xfer_addr,
  output logic [15:0] xfer_count,
  output logic [31:0] xfer_dep,
  input  logic        xfer_done,
  input  logic [15:0] xfer_resid,
  output logic        irq,
  output logic        active,
  output logic        stopped,
  output logic        dead,
  output logic [31:0] cmd_ptr
);
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_EXEC, S_XFER, S_WAIT, S_WB, S_NEXT, S_GATE, S_STOP, S_DEAD
  } st_t;

  st_t         st;
  logic [31:0] ptr, w0, w1, w2;
  logic [1:0]  idx;
  logic [15:0] resid;

  function automatic logic pol(input logic [1:0] p, input logic c);
    case (p)
      2'd0:    pol = 1'b0;
      2'd1:    pol = c;
      2'd2:    pol = !c;
      default: pol = 1'b1;
    endcase
  endfunction

  wire [15:0] cmd       = w0[31:16];
  wire [3:0]  op        = cmd[15:12];
  wire        wait_hold = pol(cmd[1:0], wait_cond);
  wire        br_take   = pol(cmd[3:2], br_cond);

  assign mem_req    = (st == S_FETCH) || (st == S_WB);
  assign mem_we     = (st == S_WB);
  assign mem_addr   = {ptr[31:4], (st == S_WB) ? 4'hC : {idx, 2'b00}};
  assign mem_wdata  = {8'h80, 5'b0, int_cond, br_cond, wait_cond, resid};
  assign xfer_req   = (st == S_XFER);
  assign xfer_op    = op;
  assign xfer_key   = cmd[10:8];
  assign xfer_addr  = w1;
  assign xfer_count = w0[15:0];
  assign xfer_dep   = w2;
  assign irq        = (st == S_NEXT) && pol(cmd[5:4], int_cond);
  assign active     = !(st inside {S_IDLE, S_STOP, S_DEAD});
  assign stopped    = (st == S_STOP);
  assign dead       = (st == S_DEAD);
  assign cmd_ptr    = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ptr   <= '0;
      idx   <= '0;
      w0    <= '0;
      w1    <= '0;
      w2    <= '0;
      resid <= '0;
    end else begin
      case (st)
        S_IDLE: if (run) begin
          ptr <= {start_ptr[31:4], 4'h0};
          idx <= '0;
          st  <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) st <= S_DEAD;
          else begin
            case (idx)
              2'd0:    w0 <= mem_rdata;
              2'd1:    w1 <= mem_rdata;
              default: w2 <= mem_rdata;
            endcase
            idx <= idx + 2'd1;
            if (idx == 2'd2) st <= S_EXEC;
          end
        end
        S_EXEC: begin
          if (op == 4'd7) st <= S_STOP;
          else if (op <= 4'd5) st <= S_XFER;
          else begin
            resid <= w0[15:0];
            st    <= S_WAIT;
          end
        end
        S_XFER: if (xfer_done) begin
          resid <= xfer_resid;
          st    <= S_WAIT;
        end
        S_WAIT: if (!wait_hold) st <= S_WB;
        S_WB: if (mem_ack) st <= mem_err ? S_DEAD : S_NEXT;
        S_NEXT: begin
          ptr <= br_take ? {w2[31:4], 4'h0} : ptr + 32'd16;
          st  <= S_GATE;
        end
        S_GATE: begin
          if (!run) st <= S_IDLE;
          else if (!pause) begin
            idx <= '0;
            st  <= S_FETCH;
          end
        end
        S_STOP: begin
          if (!run) st <= S_IDLE;
          else if (wake) begin
            idx <= '0;
            st  <= S_FETCH;
          end
        end
        default: st <= S_DEAD;
      endcase
    end
  end
endmodule

// File: rtl/dma_cmd_seq_chk.sv
module dma_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic        xfer_req,
  input logic        dead,
  input logic [31:0] cmd_ptr,
  input logic [31:0] mem_addr
);
  assert_irq_after_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(mem_req && mem_we && mem_ack));
  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_dead_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dead |=> dead);
  assert_dead_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dead |-> (!mem_req && !xfer_req));
  assert_ptr_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ptr[3:0] == 4'h0);
  assert_word_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00 && !xfer_req));
endmodule

bind dma_cmd_seq dma_cmd_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .xfer_req(xfer_req), .dead(dead), .cmd_ptr(cmd_ptr),
  .mem_addr(mem_addr)
);

// File: tb/dma_cmd_seq_tb_top.sv
module dma_cmd_seq_tb_top;
  logic clk = 0, rst_n = 0, run = 0, pause = 0, wake = 0;
  logic [31:0] start_ptr = 0;
  logic int_cond = 0, br_cond = 0, wait_cond = 0;
  logic mem_req, mem_we, mem_ack, mem_err, xfer_req, xfer_done, irq, active, stopped, dead;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, xfer_addr, xfer_dep, cmd_ptr;
  logic [3:0] xfer_op;
  logic [2:0] xfer_key;
  logic [15:0] xfer_count, xfer_resid;

  always #2 clk = ~clk;

  dma_cmd_seq dut_i (.*);

  logic [31:0] mem [0:255];
  logic        tb_wr = 0;
  logic [31:0] tb_wa = 0, tb_wd = 0, err_addr = 0;
  logic        err_en = 0;
  assign mem_ack    = mem_req;
  assign mem_rdata  = mem[mem_addr[9:2]];
  assign mem_err    = err_en && (mem_addr == err_addr);
  assign xfer_resid = xfer_count >> 1;

  always @(posedge clk) begin
    if (tb_wr) mem[tb_wa[9:2]] <= tb_wd;
    else if (mem_req && mem_we && mem_ack && !mem_err) mem[mem_addr[9:2]] <= mem_wdata;
  end

  int dcnt = 0, nxfer = 0, nirq = 0, cyc = 0;
  logic [3:0] r_op; logic [2:0] r_key; logic [31:0] r_addr, r_dep; logic [15:0] r_cnt;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && irq) nirq <= nirq + 1;
    xfer_done <= 1'b0;
    if (!rst_n) dcnt <= 0;
    else if (xfer_req && !xfer_done) begin
      if (dcnt == 2) begin
        xfer_done <= 1'b1; dcnt <= 0; nxfer <= nxfer + 1;
        r_op <= xfer_op; r_key <= xfer_key; r_addr <= xfer_addr; r_dep <= xfer_dep; r_cnt <= xfer_count;
      end else dcnt <= dcnt + 1;
    end
  end

  int checks = 0, errors = 0;
  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask
  task automatic chkv(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); tb_wr = 1; tb_wa = a; tb_wd = d;
    @(negedge clk); tb_wr = 0;
  endtask
  task automatic desc(input logic [31:0] a, input logic [15:0] req, input logic [15:0] cmd,
                      input logic [31:0] da, input logic [31:0] dep);
    wr(a, {cmd, req}); wr(a + 4, da); wr(a + 8, dep); wr(a + 12, 32'hDEADBEEF);
  endtask
  task automatic do_reset;
    @(negedge clk); rst_n = 0; run = 0; pause = 0; wake = 0;
    repeat (3) @(negedge clk); rst_n = 1;
  endtask
  task automatic wait_halt(input string tag);
    int n = 0;
    while (!stopped && !dead && n < 2000) begin @(negedge clk); n++; end
    chk(n < 2000, tag, n, 2000);
  endtask
  task automatic go(input logic [31:0] sp);
    @(negedge clk); start_ptr = sp; run = 1;
  endtask
  function automatic logic pol(input int p, input logic c);
    return (p == 3) || (p == 1 && c) || (p == 2 && !c);
  endfunction
  function automatic logic [15:0] stw(input logic i, input logic b, input logic w);
    return 16'h8000 | {13'b0, i, b, w};
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chkv("R1 active", active, 0); chkv("R1 stopped", stopped, 0); chkv("R1 dead", dead, 0);
    chkv("R1 irq", irq, 0); chkv("R1 mem_req", mem_req, 0); chkv("R1 xfer_req", xfer_req, 0);

    // R2/R3 opcode and key sweep
    for (int op = 0; op < 6; op++) begin
      for (int k = 0; k < 8; k += 5) begin
        int n0;
        do_reset();
        desc(32'h40, 16'h20 + op[15:0], {op[3:0], 1'b0, k[2:0], 8'h00}, 32'h1000 + op, 32'hA500 + k);
        desc(32'h50, 0, 16'h7000, 0, 0);
        n0 = nxfer;
        go(32'h40); wait_halt("R2 halt");
        chkv("R2 count", nxfer - n0, 1);
        chkv("R2 op", r_op, op); chkv("R2 key", r_key, k);
        chkv("R2 addr", r_addr, 32'h1000 + op); chkv("R2 dep", r_dep, 32'hA500 + k);
        chkv("R2 req", r_cnt, 16'h20 + op[15:0]);
        chkv("R3 wb", mem[8'h13], {stw(0, 0, 0), (16'h20 + op[15:0]) >> 1});
        chkv("R4 ptr", cmd_ptr, 32'h50);
        chkv("R4 no wb", mem[8'h17], 32'hDEADBEEF);
      end
    end

    // R3 no-op residual, R4 stop without transfer
    begin
      int n0;
      do_reset(); int_cond = 1; br_cond = 0; wait_cond = 1;
      desc(32'h40, 16'h0123, 16'h6000, 0, 0);
      desc(32'h50, 0, 16'h7000, 0, 0);
      n0 = nxfer;
      go(32'h40); wait_halt("R3 halt");
      chkv("R3 nop wb", mem[8'h13], {stw(1, 0, 1), 16'h0123});
      chkv("R4 no xfer", nxfer - n0, 0);
      chkv("R4 stopped", stopped, 1);
      // R10 run low returns to idle
      @(negedge clk); run = 0; repeat (2) @(negedge clk);
      chkv("R10 idle stopped", stopped, 0); chkv("R10 idle active", active, 0);
      int_cond = 0; wait_cond = 0;
    end

    // R5 interrupt policy sweep
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 2; c++) begin
        int i0;
        do_reset(); int_cond = c[0];
        desc(32'h40, 16'h10, {4'h0, 4'h0, p[1:0], 4'h0}, 32'h2000, 0);
        desc(32'h50, 0, 16'h7000, 0, 0);
        i0 = nirq;
        go(32'h40); wait_halt("R5 halt");
        chkv("R5 irq count", nirq - i0, {31'b0, pol(p, c[0])});
      end
    end
    int_cond = 0;

    // R6 branch policy sweep
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 2; c++) begin
        do_reset(); br_cond = c[0];
        desc(32'h40, 16'h4, {12'h600, p[1:0], 2'b00}, 0, 32'h80);
        desc(32'h50, 0, 16'h7000, 0, 0);
        desc(32'h80, 0, 16'h7000, 0, 0);
        go(32'h40); wait_halt("R6 halt");
        chkv("R6 next ptr", cmd_ptr, pol(p, c[0]) ? 32'h80 : 32'h50);
      end
    end
    br_cond = 0;

    // R8 alignment of start and branch target
    do_reset();
    desc(32'h40, 16'h4, 16'h600C, 0, 32'h87);
    desc(32'h80, 0, 16'h7000, 0, 0);
    go(32'h4B); wait_halt("R8 halt");
    chkv("R8 aligned ptr", cmd_ptr, 32'h80);

    // R7 wait policy sweep
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 2; c++) begin
        logic h;
        h = pol(p, c[0]);
        do_reset(); wait_cond = c[0];
        desc(32'h40, 16'h0077, {14'h1800, p[1:0]}, 0, 0);
        desc(32'h50, 0, 16'h7000, 0, 0);
        go(32'h40);
        repeat (30) @(negedge clk);
        chkv("R7 stall wb", mem[8'h13], h ? 32'hDEADBEEF : {stw(0, 0, c[0]), 16'h0077});
        if (h && p != 3) begin
          wait_cond = !c[0];
          wait_halt("R7 release");
          chkv("R7 after release", mem[8'h13], {stw(0, 0, !c[0]), 16'h0077});
        end else if (p == 3) chkv("R7 always stalled", stopped, 0);
      end
    end
    wait_cond = 0;

    // R9 wake
    do_reset();
    desc(32'h40, 16'h4, 16'h6000, 0, 0);
    desc(32'h50, 0, 16'h7000, 0, 0);
    go(32'h40); wait_halt("R9 halt");
    chkv("R9 stop ptr", cmd_ptr, 32'h50);
    desc(32'h50, 16'h4, 16'h6000, 0, 0);
    desc(32'h60, 0, 16'h7000, 0, 0);
    @(negedge clk); wake = 1; @(negedge clk); wake = 0;
    repeat (2) @(negedge clk);
    wait_halt("R9 rehalt");
    chkv("R9 wake ptr", cmd_ptr, 32'h60);

    // R10 pause between descriptors
    begin
      int n0;
      do_reset(); pause = 1;
      desc(32'h40, 16'h8, 16'h0000, 0, 0);
      desc(32'h50, 16'h8, 16'h0000, 0, 0);
      desc(32'h60, 0, 16'h7000, 0, 0);
      n0 = nxfer;
      go(32'h40);
      repeat (40) @(negedge clk);
      chkv("R10 paused xfers", nxfer - n0, 1);
      chkv("R10 paused stopped", stopped, 0);
      pause = 0;
      wait_halt("R10 halt");
      chkv("R10 resumed xfers", nxfer - n0, 2);
    end

    // R11 memory error
    begin
      int n0;
      do_reset();
      desc(32'h40, 16'h8, 16'h0000, 0, 0);
      desc(32'h50, 0, 16'h7000, 0, 0);
      err_addr = 32'h48; err_en = 1; n0 = nxfer;
      go(32'h40); wait_halt("R11 halt");
      chkv("R11 dead", dead, 1); chkv("R11 no xfer", nxfer - n0, 0);
      @(negedge clk); run = 0; repeat (3) @(negedge clk); run = 1; repeat (20) @(negedge clk);
      chkv("R11 still dead", dead, 1); chkv("R11 inactive", active, 0);
      err_en = 0;
      do_reset();
      chkv("R11 cleared", dead, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule